// File: doc/BRIEF.md
# Dual Clock Source Glitch-Free Selector

This block drives one output clock from either of two source clocks. Each source runs at a whole or half-whole multiple of a shared reference clock. A requested change of source is carried out only at a reference rising edge where both sources also rise. The select flips in the instant just after that edge, while both sources are high, so the output never shows a runt pulse or a short phase. When the incoming source is faster than 2.5 times the reference, one of its pulses is dropped during the change, which gives distribution skew room to settle.

The controller runs on the reference clock. A fence input freezes the copies of the request and of the two ratio settings that the controller acts on, so a scan or reset sequence upstream cannot disturb a change in flight. A change between two half-whole sources is refused, because such sources never rise together. The request is held, and it proceeds if a ratio later becomes whole. The request is a level, so nothing asked for while a change is in progress is lost. Reference edges are counted from the last edge at which reset was sampled low, and the user releases reset so that this edge is one where every source rises.

Top module: `dual_clk_sel`

## Requirements
- R1: Out of reset the active source is 0, busy is low and reject is low.
- R2: A ratio descriptor counts half-multiples of the reference (value 2 = 1x, 3 = 1.5x, 6 = 3x). Bit 0 set marks a half-whole ratio. Legal values are 2 and above.
- R3: The request and both ratio settings are copied on every reference edge where the fence is low. While the fence is high the copies hold, and nothing written meanwhile affects busy, reject or the active source.
- R4: A request copied at reference edge n raises busy after edge n+1 at the earliest. The active source changes at the earliest after edge n+2, and busy falls at that same edge.
- R5: With both ratios whole, the change may occur at any reference edge. Otherwise it occurs only at an even-numbered edge counted from the last edge with reset low.
- R6: The output select changes only at an instant when both source clocks are high.
- R7: If the requested source differs from the active one and both ratios are half-whole, reject is high, busy stays low and the active source is kept. Once either ratio becomes whole, the held request proceeds.
- R8: If the target ratio exceeds 5 half-steps, exactly one pulse of the target source is dropped after the change. The low phase there lasts 1.5 target periods. Otherwise no pulse is dropped.
- R9: No output high or low phase is shorter than the shorter half-period of the two sources.
- R10: If the request returns to the active source before the change is made, the pending change is cancelled and busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src0_clk | input | 1 | Source clock 0 |
| src1_clk | input | 1 | Source clock 1 |
| fence_i | input | 1 | High freezes the request and ratio copies |
| sel_req_i | input | 1 | Requested source |
| ratio0_i | input | RATIO_W | Ratio of source 0 in half-steps |
| ratio1_i | input | RATIO_W | Ratio of source 1 in half-steps |
| clk_o | output | 1 | Selected, glitch-free output clock |
| sel_o | output | 1 | Source currently driving the output |
| busy_o | output | 1 | A change has been accepted and is waiting for its edge |
| reject_o | output | 1 | The held request is refused (both ratios half-whole) |

## Verification
The assertions assume that every source rises on each reference edge for a whole ratio, and on every second edge for a half-whole ratio. They also assume that those shared edges are the even-numbered ones counted from the last edge with reset low, that ratios stay at 2 or above, and that reset and the inputs never change at a source or reference edge. The stimulus builds every clock from one time base: the reference period is 240 ns, and each source fits a whole number of periods into each 480 ns frame that starts on a shared edge. Inputs and reset change 100 ns after a reference edge, which never meets an edge of any source used. The bench changes a source's frequency only at a frame start, and for a source about to be selected it does so several cycles before the request.

// File: rtl/dcsel_pkg.sv
`timescale 1ns/1ps
// Package: shared types and counts for the dual clock selector.
// Assumes exactly two sources; the select is therefore a single bit.
package dcsel_pkg;
    localparam int NUM_SRC = 2;
    localparam int SEL_W   = $clog2(NUM_SRC);

    // Controller state: idle, or waiting for a shared rising edge.
    typedef enum logic {
        CTL_IDLE  = 1'b0,
        CTL_ALIGN = 1'b1
    } ctl_st_e;
endpackage

// File: rtl/dcsel_fence.sv
`timescale 1ns/1ps
// Module: dcsel_fence
// Holds the copies of the select request and the per-source ratios that the
// controller acts on. The copies follow the inputs on each reference edge
// while the fence is low, and they hold while it is high. Reset loads
// source 0 and a 1x ratio. Assumes the inputs are stable around ref_clk edges.
module dcsel_fence #(
    parameter int                 W           = 4,
    parameter logic [W-1:0]       RESET_RATIO = 2
) (
    input  logic                                   ref_clk,
    input  logic                                   rst_n,
    input  logic                                   fence_i,
    input  logic                                   sel_req_i,
    input  logic [dcsel_pkg::NUM_SRC-1:0][W-1:0]   ratio_i,
    output logic                                   req_q,
    output logic [dcsel_pkg::NUM_SRC-1:0][W-1:0]   ratio_q
);
    import dcsel_pkg::*;

    // Request copy: follows the input only when the fence is open.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (!fence_i) begin
            req_q <= sel_req_i;
        end
    end

    // Ratio copies, one register per source.
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_ratio
        always_ff @(posedge ref_clk) begin
            if (!rst_n) begin
                ratio_q[gi] <= RESET_RATIO;
            end else if (!fence_i) begin
                ratio_q[gi] <= ratio_i[gi];
            end
        end
    end
endmodule

// File: rtl/dcsel_ctrl.sv
`timescale 1ns/1ps
// Module: dcsel_ctrl
// Reference-domain switch controller. It accepts a pending request unless
// both ratios are half-whole, then waits for an edge that both sources share
// with the reference and flips the select there. If the target ratio exceeds
// BLANK_ABOVE half-steps, it toggles that source's drop-pulse request.
// Assumes the last reset edge is a shared rising edge of all clocks, so
// half-whole sources rise on even-numbered edges after it.
module dcsel_ctrl #(
    parameter int W           = 4,
    parameter int BLANK_ABOVE = 5
) (
    input  logic                                   ref_clk,
    input  logic                                   rst_n,
    input  logic                                   req_q,
    input  logic [dcsel_pkg::NUM_SRC-1:0][W-1:0]   ratio_q,
    output logic                                   sel_q,
    output logic                                   busy_o,
    output logic                                   reject_o,
    output logic [dcsel_pkg::NUM_SRC-1:0]          blank_tgl_o
);
    import dcsel_pkg::*;

    ctl_st_e              st_q;
    logic                 ph_q;
    logic [NUM_SRC-1:0]   half_v;
    logic                 both_half;
    logic                 pending;
    logic                 common;
    logic                 drop_pulse;
    logic [NUM_SRC-1:0]   tgl_q;

    // Half-whole flags come from bit 0 of each descriptor.
    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_half
        assign half_v[gi] = ratio_q[gi][0];
    end

    // Derived conditions for the state machine.
    always_comb begin
        both_half  = &half_v;
        pending    = (req_q != sel_q);
        common     = (half_v == '0) || ph_q;
        drop_pulse = (int'(ratio_q[req_q]) > BLANK_ABOVE);
    end

    // Edge parity since the last reset edge; high before an even edge.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            ph_q <= 1'b0;
        end else begin
            ph_q <= ~ph_q;
        end
    end

    // Switch state machine: accept, align, flip select.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            st_q  <= CTL_IDLE;
            sel_q <= 1'b0;
            tgl_q <= '0;
        end else begin
            case (st_q)
                CTL_IDLE: begin
                    if (pending && !both_half) begin
                        st_q <= CTL_ALIGN;
                    end
                end
                CTL_ALIGN: begin
                    if (!pending || both_half) begin
                        st_q <= CTL_IDLE;
                    end else if (common) begin
                        sel_q <= req_q;
                        st_q  <= CTL_IDLE;
                        if (drop_pulse) begin
                            tgl_q[req_q] <= ~tgl_q[req_q];
                        end
                    end
                end
                default: st_q <= CTL_IDLE;
            endcase
        end
    end

    // Status outputs.
    assign busy_o      = (st_q == CTL_ALIGN);
    assign reject_o    = (st_q == CTL_IDLE) && pending && both_half;
    assign blank_tgl_o = tgl_q;
endmodule

// File: rtl/dcsel_gate.sv
`timescale 1ns/1ps
// Module: dcsel_gate
// Per-source pulse gate clocked on the falling edge of its own source. When
// the drop-pulse toggle from the controller changes, the gate closes for
// exactly one source period, starting at a falling edge, so the next pulse
// is removed whole. Assumes the toggle never changes at this source's falling
// edge, because the controller moves it only on a rising edge of this source.
module dcsel_gate (
    input  logic src_clk,
    input  logic rst_n,
    input  logic blank_tgl_i,
    output logic gate_o
);
    logic seen_q;

    // Close the gate for one period per toggle; reopen on the next fall.
    always_ff @(negedge src_clk) begin
        if (!rst_n) begin
            gate_o <= 1'b1;
            seen_q <= 1'b0;
        end else if (blank_tgl_i != seen_q) begin
            gate_o <= 1'b0;
            seen_q <= blank_tgl_i;
        end else begin
            gate_o <= 1'b1;
        end
    end
endmodule

// File: rtl/dual_clk_sel.sv
`timescale 1ns/1ps
// Module: dual_clk_sel (top)
// Glitch-free selector between two clock sources. The request and ratio
// copies sit behind a fence. The controller flips the select on a shared
// rising edge, and per-source gates drop one pulse for fast targets.
// Assumes the source and reference relationships stated for dcsel_ctrl.
module dual_clk_sel #(
    parameter int               RATIO_W     = 4,
    parameter int               BLANK_ABOVE = 5,
    parameter logic [RATIO_W-1:0] RESET_RATIO = 2
) (
    input  logic               ref_clk,
    input  logic               rst_n,
    input  logic               src0_clk,
    input  logic               src1_clk,
    input  logic               fence_i,
    input  logic               sel_req_i,
    input  logic [RATIO_W-1:0] ratio0_i,
    input  logic [RATIO_W-1:0] ratio1_i,
    output logic               clk_o,
    output logic               sel_o,
    output logic               busy_o,
    output logic               reject_o
);
    import dcsel_pkg::*;

    logic [NUM_SRC-1:0][RATIO_W-1:0] ratio_in;
    logic [NUM_SRC-1:0][RATIO_W-1:0] ratio_q;
    logic                            req_q;
    logic                            sel_q;
    logic [NUM_SRC-1:0]              blank_tgl;
    logic [NUM_SRC-1:0]              gate_v;
    logic [NUM_SRC-1:0]              src_v;

    assign ratio_in = {ratio1_i, ratio0_i};
    assign src_v    = {src1_clk, src0_clk};

    dcsel_fence #(.W(RATIO_W), .RESET_RATIO(RESET_RATIO)) i_fence (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .fence_i   (fence_i),
        .sel_req_i (sel_req_i),
        .ratio_i   (ratio_in),
        .req_q     (req_q),
        .ratio_q   (ratio_q)
    );

    dcsel_ctrl #(.W(RATIO_W), .BLANK_ABOVE(BLANK_ABOVE)) i_ctrl (
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .req_q       (req_q),
        .ratio_q     (ratio_q),
        .sel_q       (sel_q),
        .busy_o      (busy_o),
        .reject_o    (reject_o),
        .blank_tgl_o (blank_tgl)
    );

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_gate
        dcsel_gate i_gate (
            .src_clk     (src_v[gi]),
            .rst_n       (rst_n),
            .blank_tgl_i (blank_tgl[gi]),
            .gate_o      (gate_v[gi])
        );
    end

    // Output mux: the selected source passed through its pulse gate.
    assign clk_o = src_v[sel_q] & gate_v[sel_q];
    assign sel_o = sel_q;
endmodule

// File: rtl/dcsel_chk.sv
`timescale 1ns/1ps
// Module: dcsel_chk
// Property checker bound into dual_clk_sel. It watches the ports and the
// fenced copies.
module dcsel_chk #(
    parameter int W = 4
) (
    input logic                                 ref_clk,
    input logic                                 rst_n,
    input logic                                 src0_clk,
    input logic                                 src1_clk,
    input logic                                 fence_i,
    input logic                                 sel_o,
    input logic                                 busy_o,
    input logic                                 reject_o,
    input logic                                 req_q,
    input logic [dcsel_pkg::NUM_SRC-1:0][W-1:0] ratio_q
);
    // R1: first cycle out of reset shows source 0, idle, no refusal.
    a_r1_reset_state: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sel_o == 1'b0 && !busy_o && !reject_o))
        else $error("a_r1_reset_state");

    // R3: with the fence high the copies do not move.
    a_r3_fence_hold: assert property (@(posedge ref_clk) disable iff (!rst_n)
        fence_i |=> ($stable(req_q) && $stable(ratio_q)))
        else $error("a_r3_fence_hold");

    // R4: a select change is preceded by busy.
    a_r4_busy_before: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (sel_o != $past(sel_o)) |-> $past(busy_o))
        else $error("a_r4_busy_before");

    // R4: busy is gone once the select has changed.
    a_r4_busy_after: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (sel_o != $past(sel_o)) |-> !busy_o)
        else $error("a_r4_busy_after");

    // R7: a refused request leaves the active source in place.
    a_r7_reject_keeps: assert property (@(posedge ref_clk) disable iff (!rst_n)
        reject_o |=> (sel_o == $past(sel_o)))
        else $error("a_r7_reject_keeps");

    // R6: the select only moves while both sources are high.
    always @(sel_o) begin
        if (rst_n) begin
            a_r6_flip_high: assert (src0_clk && src1_clk)
                else $error("a_r6_flip_high");
        end
    end
endmodule

bind dual_clk_sel dcsel_chk #(.W(RATIO_W)) i_dcsel_chk (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .src0_clk (src0_clk),
    .src1_clk (src1_clk),
    .fence_i  (fence_i),
    .sel_o    (sel_o),
    .busy_o   (busy_o),
    .reject_o (reject_o),
    .req_q    (req_q),
    .ratio_q  (ratio_q)
);

// File: tb/test_dual_clk_sel.sv
`timescale 1ns/1ps
// Bench: clocks from one time base, a behavioural reference model compared
// each reference cycle, and a monitor that measures every output phase.
module test_dual_clk_sel;
    localparam int REF_PERIOD = 240;
    localparam int FRAME      = 2 * REF_PERIOD;

    logic       ref_clk = 1'b0;
    logic       src0_clk = 1'b0;
    logic       src1_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fence = 1'b0;
    logic       req = 1'b0;
    logic [3:0] r0 = 4'd2;
    logic [3:0] r1 = 4'd2;
    logic       clk_o, sel_o, busy_o, reject_o;

    int  hg0 = 2;
    int  hg1 = 2;
    int  n_chk = 0;
    int  n_bad = 0;
    int  edge_idx = 0;
    bit  mon_en = 0;
    real last_t = 0.0;
    real max_low = 0.0;

    // Model state.
    int m_ph, m_req, m_r0, m_r1, m_sel, m_busy;
    int mh0, mh1, mcom;

    dual_clk_sel i_dual_clk_sel (
        .ref_clk(ref_clk), .rst_n(rst_n), .src0_clk(src0_clk), .src1_clk(src1_clk),
        .fence_i(fence), .sel_req_i(req), .ratio0_i(r0), .ratio1_i(r1),
        .clk_o(clk_o), .sel_o(sel_o), .busy_o(busy_o), .reject_o(reject_o)
    );

    // Reference clock: rising edges at multiples of REF_PERIOD.
    initial begin
        #(REF_PERIOD);
        forever begin
            ref_clk = 1'b1; #(REF_PERIOD/2);
            ref_clk = 1'b0; #(REF_PERIOD/2);
        end
    end

    // Source clocks: h periods per frame, the ratio read at each frame start.
    initial begin
        #(FRAME);
        forever begin
            int h;
            h = hg0;
            repeat (h) begin
                src0_clk = 1'b1; #(REF_PERIOD/h);
                src0_clk = 1'b0; #(REF_PERIOD/h);
            end
        end
    end
    initial begin
        #(FRAME);
        forever begin
            int h;
            h = hg1;
            repeat (h) begin
                src1_clk = 1'b1; #(REF_PERIOD/h);
                src1_clk = 1'b0; #(REF_PERIOD/h);
            end
        end
    end

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_real(input bit ok, input real act, input real exp, input string tag);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0.2f expected %0.2f at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each reference edge.
    always @(posedge ref_clk) begin
        edge_idx++;
        if (!rst_n) begin
            m_ph = 0; m_req = 0; m_r0 = 2; m_r1 = 2; m_sel = 0; m_busy = 0;
        end else begin
            mh0 = m_r0 % 2; mh1 = m_r1 % 2;
            mcom = ((mh0 == 0 && mh1 == 0) || m_ph == 1) ? 1 : 0;
            if (m_busy == 0) begin
                if (m_req != m_sel && !(mh0 == 1 && mh1 == 1)) m_busy = 1;
            end else if (m_req == m_sel || (mh0 == 1 && mh1 == 1)) begin
                m_busy = 0;
            end else if (mcom == 1) begin
                m_sel = m_req; m_busy = 0;
            end
            if (!fence) begin
                m_req = int'(req); m_r0 = int'(r0); m_r1 = int'(r1);
            end
            m_ph = 1 - m_ph;
        end
    end

    // Phase monitor (R6, R9): every phase at least the shorter half-period.
    always @(clk_o) begin
        real dur, minh;
        dur  = $realtime - last_t;
        minh = (hg0 > hg1) ? (REF_PERIOD * 1.0 / hg0) : (REF_PERIOD * 1.0 / hg1);
        if (mon_en) begin
            if (clk_o == 1'b1 && dur > max_low) max_low = dur;
            check_real(dur >= minh - 0.01, dur, minh, "R6 R9 output phase too short");
        end
        last_t = $realtime;
    end

    // One reference cycle; sample 100 ns after the edge and compare to model.
    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge ref_clk);
            #100;
            if (rst_n) begin
                check(int'(sel_o), m_sel, "R4 R5 active source vs model");
                check(int'(busy_o), m_busy, "R4 busy vs model");
                check(int'(reject_o),
                      (m_busy == 0 && m_req != m_sel && m_r0 % 2 == 1 && m_r1 % 2 == 1) ? 1 : 0,
                      "R7 reject vs model");
            end
        end
    endtask

    initial begin
        #(REF_PERIOD * 10 + 100);
        rst_n = 1'b1;
        #1;
        // R1: reset state.
        check(int'(sel_o), 0, "R1 source after reset");
        check(int'(busy_o), 0, "R1 busy after reset");
        check(int'(reject_o), 0, "R1 reject after reset");
        tick(4);
        mon_en = 1;

        // R4: both ratios whole, switch to source 1 (4 half-steps, no drop).
        r1 = 4'd4; hg1 = 4;
        tick(4);
        max_low = 0.0;
        req = 1'b1;
        tick(1);
        check(int'(busy_o), 0, "R4 not busy right after copy");
        tick(1);
        check(int'(busy_o), 1, "R4 busy after acceptance");
        check(int'(sel_o), 0, "R4 source still 0 while busy");
        tick(1);
        check(int'(sel_o), 1, "R4 switched on third edge");
        check(int'(busy_o), 0, "R4 busy cleared at switch");
        tick(3);
        check_real(max_low <= 120.01, max_low, 120.0, "R8 no dropped pulse for 2x target");

        // R5 R2: source 0 goes to 1.5x; switch back only on an even edge.
        r0 = 4'd3; hg0 = 3;
        tick(5);
        req = 1'b0;
        for (int k = 0; k < 8 && sel_o != 1'b0; k++) tick(1);
        check(int'(sel_o), 0, "R5 switched to half-whole source");
        check(edge_idx % 2, 0, "R5 switch edge is even");

        // R7 R2: both half-whole, request refused and kept.
        r1 = 4'd5; hg1 = 5;
        tick(4);
        req = 1'b1;
        tick(2);
        check(int'(reject_o), 1, "R2 R7 reject raised for half pair");
        tick(4);
        check(int'(sel_o), 0, "R7 source kept while refused");
        check(int'(busy_o), 0, "R7 not busy while refused");
        r0 = 4'd4; hg0 = 4;
        for (int k = 0; k < 8 && sel_o != 1'b1; k++) tick(1);
        check(int'(sel_o), 1, "R7 held request proceeds after ratio change");
        check(edge_idx % 2, 0, "R5 switch edge is even with half target");

        // R8: target 3x (6 half-steps) drops one pulse: low phase 1.5 x 80 ns.
        r0 = 4'd6; hg0 = 6;
        tick(4);
        max_low = 0.0;
        req = 1'b0;
        tick(6);
        check(int'(sel_o), 0, "R8 switched to fast source");
        check_real(max_low > 119.99 && max_low < 120.01, max_low, 120.0,
                   "R8 one dropped pulse");

        // R3: fence high, request and a half ratio do not reach the controller.
        fence = 1'b1;
        tick(1);
        req = 1'b1; r0 = 4'd5;
        tick(5);
        check(int'(sel_o), 0, "R3 source held under fence");
        check(int'(busy_o), 0, "R3 no busy under fence");
        check(int'(reject_o), 0, "R3 no reject under fence");
        r0 = 4'd6;
        tick(1);
        fence = 1'b0;
        for (int k = 0; k < 8 && sel_o != 1'b1; k++) tick(1);
        check(int'(sel_o), 1, "R3 request acted on after fence opens");
        tick(2);

        // R10: request withdrawn before the switch edge.
        req = 1'b0;
        tick(1);
        req = 1'b1;
        tick(1);
        check(int'(busy_o), 1, "R10 busy after brief request");
        tick(1);
        check(int'(busy_o), 0, "R10 busy dropped on withdrawal");
        tick(4);
        check(int'(sel_o), 1, "R10 source unchanged after withdrawal");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(REF_PERIOD * 4000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule